// File: doc/BRIEF.md
# Half-Integer Selectable Clock Divider

This block derives a sampling clock from a fast system clock. A 3-bit select chooses one of seven division ratios: 1, 1.5, 2, 3, 4, 5.5 and 6. A separate polarity input can invert the divided clock. The half-integer ratios are built from both edges of the system clock. A rising-edge register and a falling-edge register each toggle on their own edge, and the output is the XOR of the two. Each output transition therefore comes from exactly one flop.

The block samples the select and the polarity only at an output period boundary. A period that has started always completes with the shape it began with, so changing the ratio cannot produce a runt pulse. Logic in the system clock domain gets a strobe. The strobe is high for one system clock cycle in each output period: the cycle in which that period begins.

Top module: `hcd_clk_divider`

## Requirements
- R1: Select codes 0 and 7 give ratio 1. The output period is 2 system-clock half-cycles, with 1 half-cycle at the active level.
- R2: Code 1 gives ratio 1.5. The period is 3 half-cycles, of which the first 2 are at the active level.
- R3: Codes 2, 3 and 4 give periods of 4, 6 and 8 half-cycles, with the first half of each period at the active level.
- R4: Code 5 gives a period of 11 half-cycles with 6 active. Code 6 gives 12 half-cycles with 6 active.
- R5: When the polarity input is 0, the active level is high. When it is 1, the output is inverted and each period begins low.
- R6: While reset is high, the divided clock and the strobe are low. Reset loads ratio 1 with normal polarity. The first output period after reset is therefore 2 half-cycles long, whatever the select input holds.
- R7: The select and polarity inputs take effect only at an output period boundary. Every completed period has the exact length and active time of either the old setting or the new one, never a runt. A new setting is adopted within one old period.
- R8: Each output period begins with its active level, at a rising or a falling system clock edge. The strobe is high for exactly one system clock cycle per period, the cycle (rising edge to rising edge) in which that period begins. At ratio 1 it is high every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; both edges are used |
| rst_i | input | 1 | Synchronous active-high reset |
| ratio_sel_i | input | 3 | Division ratio select code |
| invert_i | input | 1 | Output polarity, 1 inverts |
| div_clk_o | output | 1 | Divided clock |
| tick_o | output | 1 | One-cycle strobe marking the cycle in which each output period begins |

## Verification
The bench measures every output period in half-cycles and checks both the period length and the active time. It does this for every select code under both polarities.

- Duty check: a wrong toggle on the falling edge would leave the period length of the 1.5 and 5.5 ratios intact. Measuring the active time catches this, because such a design still gets the duty wrong.
- Ratio changes: random select changes land at arbitrary phases, including periods that end at a falling edge. A design that reloads its ratio mid-period then shows a period matching neither the old setting nor the new one.
- Strobe alignment: the strobe is compared every cycle with where the measured period actually began. An inverted output that kept its non-inverted phase would be caught here.
- Reset: the first period after reset must be ratio 1 even though the select is set to 3 during reset.

// File: rtl/hcd_pkg.sv
`timescale 1ns/1ps
package hcd_pkg;

    localparam int SEL_W  = 3;
    localparam int HALF_W = 4;

    typedef logic [HALF_W-1:0] half_t;

    typedef enum logic [SEL_W-1:0] {
        DIV_1   = 3'd0,
        DIV_1P5 = 3'd1,
        DIV_2   = 3'd2,
        DIV_3   = 3'd3,
        DIV_4   = 3'd4,
        DIV_5P5 = 3'd5,
        DIV_6   = 3'd6,
        DIV_RSV = 3'd7
    } div_sel_e;

    // One output period described in system-clock half-cycles
    typedef struct packed {
        half_t period;
        half_t active;
    } ratio_t;

    function automatic ratio_t make_ratio(int unsigned halves);
        ratio_t r;
        r.period = half_t'(halves);
        r.active = half_t'((halves + 1) / 2);
        return r;
    endfunction

    function automatic ratio_t ratio_of(logic [SEL_W-1:0] code);
        ratio_t r;
        case (div_sel_e'(code))
            DIV_1P5: r = make_ratio(3);
            DIV_2:   r = make_ratio(4);
            DIV_3:   r = make_ratio(6);
            DIV_4:   r = make_ratio(8);
            DIV_5P5: r = make_ratio(11);
            DIV_6:   r = make_ratio(12);
            default: r = make_ratio(2);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hcd_ratio_decode.sv
`timescale 1ns/1ps
module hcd_ratio_decode
    import hcd_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    output ratio_t           ratio_o
);

    always_comb begin
        ratio_o = ratio_of(sel_i);
    end

endmodule

// File: rtl/hcd_phase_seq.sv
`timescale 1ns/1ps
module hcd_phase_seq
    import hcd_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  ratio_t next_ratio_i,
    input  logic   next_inv_i,
    output logic   first_half_o,
    output logic   second_half_o,
    output logic   tick_o
);

    ratio_t cur_q;
    logic   inv_q;
    half_t  pos_q;
    half_t  pos_p1;
    half_t  pos_p2;
    half_t  pos_d;
    logic   mid_wrap;
    logic   end_wrap;
    logic   boundary;

    always_comb begin
        pos_p1   = pos_q + half_t'(1);
        pos_p2   = pos_q + half_t'(2);
        // period ends at the falling edge inside this cycle
        mid_wrap = (pos_p1 == cur_q.period);
        // period ends exactly at the next rising edge
        end_wrap = (pos_p2 == cur_q.period);
        boundary = mid_wrap | end_wrap;

        first_half_o = (pos_q < cur_q.active) ^ inv_q;
        if (mid_wrap) begin
            second_half_o = ~next_inv_i;
        end else begin
            second_half_o = (pos_p1 < cur_q.active) ^ inv_q;
        end

        if (mid_wrap) begin
            pos_d = half_t'(1);
        end else if (end_wrap) begin
            pos_d = '0;
        end else begin
            pos_d = pos_p2;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q  <= make_ratio(2);
            inv_q  <= 1'b0;
            pos_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            pos_q  <= pos_d;
            tick_o <= (pos_q == '0) | mid_wrap;
            if (boundary) begin
                cur_q <= next_ratio_i;
                inv_q <= next_inv_i;
            end
        end
    end

    AST_POS_INSIDE_PERIOD: assert property (@(posedge clk_i) disable iff (rst_i)
        pos_q < cur_q.period); // R7

    AST_SETTING_ONLY_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (rst_i)
        !boundary |=> ($stable(cur_q) && $stable(inv_q))); // R7

    AST_RESET_LOADS_UNITY: assert property (@(posedge clk_i)
        rst_i |=> (cur_q.period == half_t'(2) && !inv_q && !tick_o)); // R6

    AST_UNITY_TICK_EVERY_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (cur_q.period == half_t'(2)) |=> tick_o); // R8

endmodule

// File: rtl/hcd_edge_gen.sv
`timescale 1ns/1ps
module hcd_edge_gen (
    input  logic clk_i,
    input  logic rst_i,
    input  logic first_half_i,
    input  logic second_half_i,
    output logic div_clk_o
);

    logic rise_tgl_q;
    logic fall_tgl_q;
    logic fall_req_q;
    logic late_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rise_tgl_q <= 1'b0;
            fall_req_q <= 1'b0;
            late_q     <= 1'b0;
        end else begin
            rise_tgl_q <= rise_tgl_q ^ (first_half_i ^ late_q);
            fall_req_q <= first_half_i ^ second_half_i;
            late_q     <= second_half_i;
        end
    end

    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            fall_tgl_q <= 1'b0;
        end else begin
            fall_tgl_q <= fall_tgl_q ^ fall_req_q;
        end
    end

    assign div_clk_o = rise_tgl_q ^ fall_tgl_q;

    AST_LATE_HALF_REACHES_PIN: assert property (@(posedge clk_i) disable iff (rst_i)
        !rst_i |=> (div_clk_o == $past(second_half_i))); // R7

endmodule

// File: rtl/hcd_clk_divider.sv
`timescale 1ns/1ps
module hcd_clk_divider
    import hcd_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [SEL_W-1:0] ratio_sel_i,
    input  logic             invert_i,
    output logic             div_clk_o,
    output logic             tick_o
);

    ratio_t next_ratio;
    logic   first_half;
    logic   second_half;

    hcd_ratio_decode u_decode (
        .sel_i   (ratio_sel_i),
        .ratio_o (next_ratio)
    );

    hcd_phase_seq u_seq (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .next_ratio_i  (next_ratio),
        .next_inv_i    (invert_i),
        .first_half_o  (first_half),
        .second_half_o (second_half),
        .tick_o        (tick_o)
    );

    hcd_edge_gen u_edges (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .first_half_i  (first_half),
        .second_half_i (second_half),
        .div_clk_o     (div_clk_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        rst_i |=> !tick_o); // R6

endmodule

// File: tb/test_hcd_clk_divider.sv
`timescale 1ns/1ps
module test_hcd_clk_divider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel = 3'd0;
    logic       inv = 1'b0;
    logic       div_clk;
    logic       tick;

    always #4 clk = ~clk;

    hcd_clk_divider i_hcd_clk_divider (
        .clk_i       (clk),
        .rst_i       (rst),
        .ratio_sel_i (sel),
        .invert_i    (inv),
        .div_clk_o   (div_clk),
        .tick_o      (tick)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // monitor state
    bit mon_on = 1'b0;
    bit mon_inv = 1'b0;
    bit armed = 1'b0;
    int old_code = 0;
    int new_code = 0;
    bit have_rise = 1'b0;
    int pcnt = 0;
    int hcnt = 0;
    bit prev_lvl = 1'b0;
    bit rise_pos = 1'b0;
    bit tick_s = 1'b0;
    bit pos_seen = 1'b0;
    bit first_taken = 1'b0;
    int first_period = -1;

    function automatic int exp_p(int c);
        case (c)
            1: return 3;
            2: return 4;
            3: return 6;
            4: return 8;
            5: return 11;
            6: return 12;
            default: return 2;
        endcase
    endfunction

    function automatic int exp_h(int c);
        case (c)
            1: return 2;
            2: return 2;
            3: return 3;
            4: return 4;
            5: return 6;
            6: return 6;
            default: return 1;
        endcase
    endfunction

    function automatic string tag_of(int c);
        case (c)
            1: return "R2";
            2, 3, 4: return "R3";
            5, 6: return "R4";
            default: return "R1";
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic judge();
        bit ok_old;
        bit ok_new;
        string req;
        ok_old = (pcnt == exp_p(old_code)) && (hcnt == exp_h(old_code));
        ok_new = (pcnt == exp_p(new_code)) && (hcnt == exp_h(new_code));
        if (old_code != new_code) req = "R7";
        else if (mon_inv) req = "R5";
        else req = tag_of(old_code);
        check(ok_old || ok_new, req, "period halves", pcnt, exp_p(new_code));
        check(ok_old || ok_new, req, "active halves", hcnt, exp_h(new_code));
        if (!first_taken) begin
            first_taken = 1'b1;
            first_period = pcnt;
        end
        if (ok_new) old_code = new_code;
    endtask

    task automatic sample_half(bit at_pos);
        bit lvl;
        bit rise;
        lvl  = div_clk ^ mon_inv;
        rise = lvl && !prev_lvl;
        if (!mon_on) begin
            armed = 1'b0;
            have_rise = 1'b0;
            pos_seen = 1'b0;
        end else if (!armed) begin
            armed = 1'b1;
        end else begin
            if (rise) begin
                if (have_rise) judge();
                have_rise = 1'b1;
                pcnt = 1;
                hcnt = 1;
            end else if (have_rise) begin
                pcnt++;
                if (lvl) hcnt++;
                if (pcnt > 40) begin
                    check(1'b0, "R7", "no period start seen, halves", pcnt, exp_p(new_code));
                    have_rise = 1'b0;
                end
            end
            if (at_pos) begin
                rise_pos = rise;
                tick_s = tick;
                pos_seen = 1'b1;
            end else if (pos_seen) begin
                check(tick_s == (rise_pos || rise), "R8", "strobe",
                      int'(tick_s), int'(rise_pos || rise));
            end
        end
        prev_lvl = lvl;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2 sample_half(1'b1);
            @(negedge clk);
            #2 sample_half(1'b0);
        end
    end

    task automatic set_code(int c, int hold);
        @(negedge clk);
        #1 sel = 3'(c);
        new_code = c;
        repeat (hold) @(posedge clk);
        check(old_code == new_code, "R7", "setting adopted", old_code, new_code);
    endtask

    task automatic set_inv(bit v);
        mon_on = 1'b0;
        @(negedge clk);
        #1 inv = v;
        repeat (20) @(posedge clk);
        mon_inv = v;
        old_code = new_code;
        mon_on = 1'b1;
        repeat (20) @(posedge clk);
    endtask

    initial begin
        sel = 3'd3;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check(div_clk == 1'b0, "R6", "clock in reset", int'(div_clk), 0);
        check(tick == 1'b0, "R6", "strobe in reset", int'(tick), 0);
        @(negedge clk);
        #1 rst = 1'b0;
        old_code = 0;
        new_code = 3;
        mon_on = 1'b1;
        repeat (40) @(posedge clk);
        check(first_period == 2, "R6", "first period after reset", first_period, 2);
        check(old_code == 3, "R7", "setting adopted after reset", old_code, 3);

        // directed sweep, normal polarity (R1 R2 R3 R4)
        for (int c = 0; c < 8; c++) set_code(c, 40);
        // inverted polarity (R5)
        set_inv(1'b1);
        set_code(1, 40);
        set_code(5, 40);
        set_code(6, 40);
        set_code(0, 40);
        set_inv(1'b0);

        // random ratio changes at arbitrary phases (R7)
        void'($urandom(32'd20250));
        for (int i = 0; i < 40; i++) begin
            if (i == 20) set_inv(1'b1);
            if (i == 30) set_inv(1'b0);
            set_code(int'($urandom % 8), 16 + int'($urandom % 30));
        end

        repeat (10) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule